// File: doc/BRIEF.md
# MESI snooping cache controller

A small direct-mapped write-back cache controller that keeps one data word per line coherent with other caches on a shared snooping bus. It uses an invalidation-based protocol with four line states. It serves processor loads and stores. It issues read, read-for-ownership and write-back transactions as a bus master. It watches every foreign bus transaction on a snoop input, supplying data or invalidating lines as the protocol demands.

On a read miss the controller samples a wired-OR "shared" line when its bus read completes. If no other cache claims the block, the line is loaded as exclusive-clean, and a later store to it completes with no bus traffic at all. The controller drives its own contribution to that shared line whenever a snooped read finds a valid copy here. The arbiter, memory and the OR-ing of all caches' shared outputs sit outside the block. The snoop input is assumed never to carry this controller's own transactions, and a snoop never coincides with `bus_done`.

Line states: `LN_I` (invalid), `LN_S` (shared clean), `LN_E` (exclusive clean), `LN_M` (modified). Controller states: `FS_IDLE` (accepting requests; hits served here), `FS_EVICT` (writing back a modified victim), `FS_FETCH` (waiting for a read or read-for-ownership to complete). Transitions: `FS_IDLE`→`FS_EVICT` on a miss whose victim is `LN_M`; `FS_IDLE`→`FS_FETCH` on any other miss or on a store to an `LN_S` line; `FS_EVICT`→`FS_FETCH` and `FS_FETCH`→`FS_IDLE` on `bus_done`. Line transitions: fill to `LN_E`/`LN_S` by shared-line sample; store fill to `LN_M`; `LN_E`→`LN_M` on a store hit; snooped read takes `LN_E`/`LN_M` to `LN_S`; snooped read-for-ownership takes any valid line to `LN_I`.

Top module: `mesi_snoop_ctl`

## Requirements
- R1: After reset every line is invalid, so the first load to any address issues a bus read, and `cpu_resp_valid`, `bus_req_valid` and `supply_valid` are low while `cpu_req_ready` is high.
- R2: A load miss raises `bus_req_valid` with `bus_req_cmd` = 1 (read) and the full request address, holds both until `bus_done`, and returns `bus_rdata` on `cpu_resp_rdata` with `cpu_resp_valid` in the cycle after `bus_done`.
- R3: A load fill with `shared_in` low at `bus_done` leaves the line exclusive, and a following store to it completes with no bus request.
- R4: A load fill with `shared_in` high leaves the line shared, and a following store to it issues `bus_req_cmd` = 2 (read-for-ownership).
- R5: A load hitting a valid line, or a store hitting an exclusive or modified line, raises `cpu_resp_valid` in the cycle after acceptance with no bus request; a store response echoes the stored word.
- R6: `shared_out` is high in the same cycle as a snooped read (`snp_cmd` = 1) whose address matches a valid line here, and low for a snooped read that misses or any other snooped command.
- R7: A snooped read hitting an exclusive or modified line pulses `supply_valid` in the next cycle with the line's address and data, and leaves the line shared.
- R8: A snooped read-for-ownership (`snp_cmd` = 2) hitting an exclusive or modified line pulses `supply_valid` with the line's data in the next cycle and invalidates it.
- R9: A snooped read-for-ownership hitting a shared line invalidates it, and supplies the data only when `responder_en` is high.
- R10: A store miss issues a read-for-ownership, writes the store word over the fill, responds with that word, and leaves the line modified.
- R11: A miss whose victim line is modified first issues `bus_req_cmd` = 3 (write-back) with the victim's address and data, then issues the fetch for the new address.
- R12: When a snoop targets the same line index as a processor request in the same cycle, `cpu_req_ready` is low for that cycle; the snoop's state change takes effect first and the request is taken afterwards against the updated line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_resp_valid | output | 1 | One-cycle response pulse |
| cpu_resp_rdata | output | DATA_W | Load data, or stored word for stores |
| bus_req_valid | output | 1 | Bus master request held until done |
| bus_req_cmd | output | 2 | 1 read, 2 read-for-ownership, 3 write-back |
| bus_req_addr | output | ADDR_W | Bus transaction address |
| bus_req_wdata | output | DATA_W | Write-back data |
| bus_done | input | 1 | Current bus transaction completes this cycle |
| bus_rdata | input | DATA_W | Fill data, valid with bus_done |
| shared_in | input | 1 | Wired-OR shared line, sampled with bus_done |
| snp_valid | input | 1 | Foreign bus transaction visible |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_req_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| shared_out | output | 1 | This cache's contribution to the shared line |
| supply_valid | output | 1 | Snoop data supply pulse |
| supply_addr | output | ADDR_W | Address of supplied block |
| supply_data | output | DATA_W | Supplied block data |
| responder_en | input | 1 | This cache answers for shared lines on read-for-ownership |

## Verification
The processor path and the snoop path can both try to change the same line in a single cycle. The bench provokes this by first loading a block as exclusive. It then presents, on the same clock, a store to that block and a snooped read of it. The outcome is right if `cpu_req_ready` drops for that cycle, `shared_out` rises at once, and the block is supplied next cycle. The store must then go out as a read-for-ownership rather than completing silently, which proves the line had already been demoted to shared.

// File: rtl/mesi_ctl_pkg.sv
package mesi_ctl_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_E = 2'd2,
        LN_M = 2'd3
    } line_st_t;

    typedef enum logic [1:0] {
        BC_NONE  = 2'd0,
        BC_RD    = 2'd1,
        BC_RDX   = 2'd2,
        BC_FLUSH = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_EVICT = 2'd1,
        FS_FETCH = 2'd2
    } ctl_st_t;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_ctl_pkg::*;
#(
    parameter int LINES  = 8,
    parameter int TAG_W  = 13,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  p_idx,
    output logic [TAG_W-1:0]  p_tag,
    output line_st_t          p_st,
    output logic [DATA_W-1:0] p_data,
    input  logic              p_we,
    input  logic [TAG_W-1:0]  p_wtag,
    input  line_st_t          p_wst,
    input  logic [DATA_W-1:0] p_wdata,
    input  logic [IDX_W-1:0]  s_idx,
    output logic [TAG_W-1:0]  s_tag,
    output line_st_t          s_st,
    output logic [DATA_W-1:0] s_data,
    input  logic              s_we,
    input  line_st_t          s_wst
);

    line_st_t          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    assign p_tag  = tag_q[p_idx];
    assign p_st   = st_q[p_idx];
    assign p_data = data_q[p_idx];
    assign s_tag  = tag_q[s_idx];
    assign s_st   = st_q[s_idx];
    assign s_data = data_q[s_idx];

    // Processor-side write is applied after the snoop write, so it wins a clash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) st_q[i] <= LN_I;
        end else begin
            if (s_we) st_q[s_idx] <= s_wst;
            if (p_we) st_q[p_idx] <= p_wst;
        end
    end

    always_ff @(posedge clk) begin
        if (p_we) begin
            tag_q[p_idx]  <= p_wtag;
            data_q[p_idx] <= p_wdata;
        end
    end

    // R12: the request gate keeps processor and snoop updates off the same line
    assert_no_line_clash_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (p_we && s_we) |-> (p_idx != s_idx));

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_ctl_pkg::*;
(
    input  logic     match,
    input  bus_cmd_t cmd,
    input  line_st_t st,
    input  logic     responder_en,
    output logic     shared,
    output logic     supply,
    output logic     upd,
    output line_st_t new_st
);

    always_comb begin
        shared = match && (cmd == BC_RD);
        supply = 1'b0;
        upd    = 1'b0;
        new_st = st;
        if (match) begin
            unique case (st)
                LN_M, LN_E: begin
                    if (cmd == BC_RD) begin
                        supply = 1'b1;
                        upd    = 1'b1;
                        new_st = LN_S;
                    end else if (cmd == BC_RDX) begin
                        supply = 1'b1;
                        upd    = 1'b1;
                        new_st = LN_I;
                    end
                end
                LN_S: begin
                    if (cmd == BC_RDX) begin
                        supply = responder_en;
                        upd    = 1'b1;
                        new_st = LN_I;
                    end
                end
                LN_I: ;
            endcase
        end
    end

endmodule

// File: rtl/mesi_snoop_ctl.sv
module mesi_snoop_ctl
    import mesi_ctl_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              shared_out,
    output logic              supply_valid,
    output logic [ADDR_W-1:0] supply_addr,
    output logic [DATA_W-1:0] supply_data,
    input  logic              responder_en
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    ctl_st_t           state_q, state_d;
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_write;
    logic [DATA_W-1:0] lat_wdata;

    logic [IDX_W-1:0]  req_idx, lat_idx, snp_idx, p_idx;
    logic [TAG_W-1:0]  req_tag, lat_tag, snp_tag;
    logic [TAG_W-1:0]  p_tag, s_tag, p_wtag;
    line_st_t          p_st, s_st, p_wst, s_wst;
    logic [DATA_W-1:0] p_data, s_data, p_wdata;
    logic              p_we, s_we, s_match, supply_now;
    logic              p_match, can_serve, conflict, accept;
    bus_cmd_t          cmd_now;

    assign req_idx = cpu_req_addr[IDX_W-1:0];
    assign req_tag = cpu_req_addr[ADDR_W-1:IDX_W];
    assign lat_idx = lat_addr[IDX_W-1:0];
    assign lat_tag = lat_addr[ADDR_W-1:IDX_W];
    assign snp_idx = snp_addr[IDX_W-1:0];
    assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
    assign p_idx   = (state_q == FS_IDLE) ? req_idx : lat_idx;

    mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .p_idx(p_idx), .p_tag(p_tag), .p_st(p_st), .p_data(p_data),
        .p_we(p_we), .p_wtag(p_wtag), .p_wst(p_wst), .p_wdata(p_wdata),
        .s_idx(snp_idx), .s_tag(s_tag), .s_st(s_st), .s_data(s_data),
        .s_we(s_we), .s_wst(s_wst)
    );

    assign s_match = snp_valid && (s_st != LN_I) && (s_tag == snp_tag);

    mesi_snoop_unit u_snoop (
        .match(s_match), .cmd(bus_cmd_t'(snp_cmd)), .st(s_st),
        .responder_en(responder_en), .shared(shared_out),
        .supply(supply_now), .upd(s_we), .new_st(s_wst)
    );

    assign p_match   = (p_st != LN_I) && (p_tag == req_tag);
    assign can_serve = p_match && (!cpu_req_write || p_st == LN_E || p_st == LN_M);
    assign conflict  = snp_valid && (snp_idx == req_idx);
    assign cpu_req_ready = (state_q == FS_IDLE) && !conflict;
    assign accept    = cpu_req_valid && cpu_req_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE:
                if (accept && !can_serve)
                    state_d = (p_st == LN_M && !p_match) ? FS_EVICT : FS_FETCH;
            FS_EVICT: if (bus_done) state_d = FS_FETCH;
            FS_FETCH: if (bus_done) state_d = FS_IDLE;
            default:  state_d = FS_IDLE;
        endcase
    end

    // Outputs and line-store writes
    always_comb begin
        cmd_now       = BC_NONE;
        bus_req_addr  = lat_addr;
        bus_req_wdata = p_data;
        p_we          = 1'b0;
        p_wtag        = req_tag;
        p_wst         = LN_M;
        p_wdata       = cpu_req_wdata;
        unique case (state_q)
            FS_IDLE: p_we = accept && can_serve && cpu_req_write;
            FS_EVICT: begin
                cmd_now      = BC_FLUSH;
                bus_req_addr = {p_tag, lat_idx};
            end
            FS_FETCH: begin
                cmd_now = lat_write ? BC_RDX : BC_RD;
                p_we    = bus_done;
                p_wtag  = lat_tag;
                p_wst   = lat_write ? LN_M : (shared_in ? LN_S : LN_E);
                p_wdata = lat_write ? lat_wdata : bus_rdata;
            end
            default: ;
        endcase
    end

    assign bus_req_valid = (state_q != FS_IDLE);
    assign bus_req_cmd   = cmd_now;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_resp_valid <= 1'b0;
            supply_valid   <= 1'b0;
            lat_write      <= 1'b0;
        end else begin
            cpu_resp_valid <= (accept && can_serve) || (state_q == FS_FETCH && bus_done);
            supply_valid   <= supply_now;
            if (accept) lat_write <= cpu_req_write;
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            lat_addr  <= cpu_req_addr;
            lat_wdata <= cpu_req_wdata;
        end
        if (accept)
            cpu_resp_rdata <= cpu_req_write ? cpu_req_wdata : p_data;
        else
            cpu_resp_rdata <= lat_write ? lat_wdata : bus_rdata;
        supply_addr <= snp_addr;
        supply_data <= s_data;
    end

    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_done) |=>
            (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr)));

    // R5 and R3: a hit is answered next cycle with no bus traffic
    assert_hit_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && can_serve) |=> (cpu_resp_valid && !bus_req_valid));

    assert_shared_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shared_out |-> (snp_valid && snp_cmd == BC_RD));

    assert_supply_follows_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        supply_valid |-> $past(snp_valid));

    assert_fetch_after_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_cmd == BC_FLUSH && bus_done) |=>
            (bus_req_valid && bus_req_cmd != BC_FLUSH));

endmodule

// File: tb/test_mesi_snoop_ctl.sv
`timescale 1ns/1ps
module test_mesi_snoop_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
    logic [15:0] cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_req_ready, cpu_resp_valid;
    logic [31:0] cpu_resp_rdata;
    logic        bus_req_valid;
    logic [1:0]  bus_req_cmd;
    logic [15:0] bus_req_addr;
    logic [31:0] bus_req_wdata;
    logic        bus_done = 1'b0, shared_in = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = 2'd0;
    logic [15:0] snp_addr = '0;
    logic        shared_out, supply_valid, responder_en = 1'b0;
    logic [15:0] supply_addr;
    logic [31:0] supply_data;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    mesi_snoop_ctl i_mesi_snoop_ctl (.*);

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_issue(input logic wr, input logic [15:0] a, input logic [31:0] wd);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
        #1;
        for (int k = 0; k < 20 && !cpu_req_ready; k++) begin
            @(negedge clk); #1;
        end
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
    endtask

    // Serves the bus and waits for the response; records what went out.
    task automatic cpu_finish(input logic [31:0] fill, input logic shr, output logic [31:0] rd,
                              output logic f_seen, output logic [15:0] f_addr, output logic [31:0] f_data,
                              output logic x_seen, output logic [1:0] x_cmd, output logic [15:0] x_addr);
        logic got = 1'b0;
        rd = '0; f_seen = 0; f_addr = '0; f_data = '0; x_seen = 0; x_cmd = 2'd0; x_addr = '0;
        for (int k = 0; k < 40 && !got; k++) begin
            if (bus_done) bus_done = 1'b0;
            else if (bus_req_valid) begin
                if (bus_req_cmd == 2'd3) begin
                    f_seen = 1; f_addr = bus_req_addr; f_data = bus_req_wdata;
                end else begin
                    x_seen = 1; x_cmd = bus_req_cmd; x_addr = bus_req_addr;
                end
                bus_done = 1'b1; bus_rdata = fill; shared_in = shr;
            end
            if (cpu_resp_valid) begin
                got = 1'b1; rd = cpu_resp_rdata;
            end else @(negedge clk);
        end
        chk(got, "response seen", 32'(got), 32'd1);
    endtask

    task automatic cpu_op(input logic wr, input logic [15:0] a, input logic [31:0] wd,
                          input logic [31:0] fill, input logic shr, output logic [31:0] rd,
                          output logic f_seen, output logic [15:0] f_addr, output logic [31:0] f_data,
                          output logic x_seen, output logic [1:0] x_cmd, output logic [15:0] x_addr);
        cpu_issue(wr, a, wd);
        cpu_finish(fill, shr, rd, f_seen, f_addr, f_data, x_seen, x_cmd, x_addr);
    endtask

    task automatic snoop(input logic [1:0] c, input logic [15:0] a, output logic shr,
                         output logic sup, output logic [31:0] sdata, output logic [15:0] saddr);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
        #1 shr = shared_out;
        @(negedge clk);
        snp_valid = 1'b0;
        sup = supply_valid; sdata = supply_data; saddr = supply_addr;
    endtask

    logic [31:0] rd, fd, sd;
    logic [15:0] fa, xa, sa;
    logic        fs, xs, sh, sp;
    logic [1:0]  xc;

    task automatic t_reset_and_fill;
        @(negedge clk);
        chk(!cpu_resp_valid && !bus_req_valid && !supply_valid, "R1 idle outputs", 0, 0);
        chk(cpu_req_ready, "R1 ready after reset", 32'(cpu_req_ready), 1);
        cpu_op(0, 16'h0010, 0, 32'hA1, 0, rd, fs, fa, fd, xs, xc, xa);
        chk(xs && xc == 2'd1, "R1 first load misses with read", 32'(xc), 1);
        chk(xa == 16'h0010, "R2 read address", 32'(xa), 32'h10);
        chk(rd == 32'hA1 && !fs, "R2 fill data", rd, 32'hA1);
    endtask

    task automatic t_exclusive_silent;
        cpu_op(1, 16'h0010, 32'hB2, 0, 0, rd, fs, fa, fd, xs, xc, xa);
        chk(!xs && !fs, "R3 silent store on exclusive", 32'(xs), 0);
        chk(rd == 32'hB2, "R5 store echo", rd, 32'hB2);
    endtask

    task automatic t_snoop_read_demote;
        snoop(2'd1, 16'h0010, sh, sp, sd, sa);
        chk(sh, "R6 shared on snoop hit", 32'(sh), 1);
        chk(sp && sd == 32'hB2 && sa == 16'h0010, "R7 supply modified data", sd, 32'hB2);
        snoop(2'd1, 16'h0090, sh, sp, sd, sa);
        chk(!sh && !sp, "R6 no shared on snoop miss", 32'(sh), 0);
        cpu_op(1, 16'h0010, 32'hC3, 32'hB2, 0, rd, fs, fa, fd, xs, xc, xa);
        chk(xs && xc == 2'd2 && rd == 32'hC3, "R7 demoted line needs ownership", 32'(xc), 2);
    endtask

    task automatic t_shared_fill;
        cpu_op(0, 16'h0021, 0, 32'h55, 1, rd, fs, fa, fd, xs, xc, xa);
        chk(xs && xc == 2'd1 && rd == 32'h55, "R4 shared fill read", rd, 32'h55);
        cpu_op(1, 16'h0021, 32'h66, 32'h55, 0, rd, fs, fa, fd, xs, xc, xa);
        chk(xs && xc == 2'd2 && xa == 16'h0021, "R4 store on shared issues ownership", 32'(xc), 2);
    endtask

    task automatic t_hits;
        cpu_op(0, 16'h0021, 0, 0, 0, rd, fs, fa, fd, xs, xc, xa);
        chk(!xs && rd == 32'h66, "R5 load hit on modified", rd, 32'h66);
        cpu_op(0, 16'h0032, 0, 32'h32, 1, rd, fs, fa, fd, xs, xc, xa);
        cpu_op(0, 16'h0032, 0, 0, 0, rd, fs, fa, fd, xs, xc, xa);
        chk(!xs && rd == 32'h32, "R5 load hit on shared", rd, 32'h32);
    endtask

    task automatic t_snoop_rdx_owned;
        snoop(2'd2, 16'h0021, sh, sp, sd, sa);
        chk(!sh && sp && sd == 32'h66, "R8 supply on ownership snoop", sd, 32'h66);
        cpu_op(0, 16'h0021, 0, 32'h67, 0, rd, fs, fa, fd, xs, xc, xa);
        chk(xs && xc == 2'd1 && rd == 32'h67, "R8 line invalidated", 32'(xs), 1);
    endtask

    task automatic t_snoop_rdx_shared;
        responder_en = 1'b0;
        snoop(2'd2, 16'h0032, sh, sp, sd, sa);
        chk(!sp, "R9 non-responder stays quiet", 32'(sp), 0);
        cpu_op(0, 16'h0032, 0, 32'h35, 1, rd, fs, fa, fd, xs, xc, xa);
        chk(xs && xc == 2'd1, "R9 shared line invalidated", 32'(xs), 1);
        responder_en = 1'b1;
        snoop(2'd2, 16'h0032, sh, sp, sd, sa);
        chk(sp && sd == 32'h35, "R9 responder supplies", sd, 32'h35);
        responder_en = 1'b0;
    endtask

    task automatic t_write_miss;
        cpu_op(1, 16'h0044, 32'h99, 32'h11, 0, rd, fs, fa, fd, xs, xc, xa);
        chk(xs && xc == 2'd2 && xa == 16'h0044 && rd == 32'h99, "R10 store miss", rd, 32'h99);
        snoop(2'd1, 16'h0044, sh, sp, sd, sa);
        chk(sp && sd == 32'h99, "R10 line modified with store word", sd, 32'h99);
    endtask

    task automatic t_evict;
        cpu_op(1, 16'h0044, 32'h77, 32'h99, 0, rd, fs, fa, fd, xs, xc, xa);
        cpu_op(0, 16'h00C4, 0, 32'hC4, 0, rd, fs, fa, fd, xs, xc, xa);
        chk(fs && fa == 16'h0044 && fd == 32'h77, "R11 victim written back", fd, 32'h77);
        chk(xs && xc == 2'd1 && xa == 16'h00C4 && rd == 32'hC4, "R11 fetch after write-back", 32'(xa), 32'hC4);
    endtask

    task automatic t_same_cycle;
        cpu_op(0, 16'h0055, 0, 32'hE5, 0, rd, fs, fa, fd, xs, xc, xa);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 16'h0055; cpu_req_wdata = 32'hF0;
        snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 16'h0055;
        #1;
        chk(!cpu_req_ready, "R12 stall on same-line snoop", 32'(cpu_req_ready), 0);
        chk(shared_out, "R6 shared during clash", 32'(shared_out), 1);
        @(negedge clk);
        snp_valid = 1'b0;
        chk(supply_valid && supply_data == 32'hE5, "R12 snoop served first", supply_data, 32'hE5);
        #1;
        chk(cpu_req_ready, "R12 ready after snoop", 32'(cpu_req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        cpu_finish(32'hE5, 0, rd, fs, fa, fd, xs, xc, xa);
        chk(xs && xc == 2'd2 && rd == 32'hF0, "R12 store sees demoted line", 32'(xc), 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_and_fill();
        t_exclusive_silent();
        t_snoop_read_demote();
        t_shared_fill();
        t_hits();
        t_snoop_rdx_owned();
        t_snoop_rdx_shared();
        t_write_miss();
        t_evict();
        t_same_cycle();
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule